// File: doc/BRIEF.md
# Random Number Generator Controller

This block is a register-mapped controller for a hardware random word source. Software uses a small 32-bit register bus to do four things: start a self-test or a seeding run, mask or unmask two interrupt causes, read the completion and error status, and pop random words. A single interrupt line reports completion and error conditions. A 32-bit xorshift generator stands in for a physical entropy source, so every word the block produces can be predicted.

After a seeding run succeeds, the block keeps a FIFO of random words topped up at one word per cycle. Software takes one word per read of the data register. A seeding run can end in a statistical failure, and the first run after reset is made to fail through a parameter. Software must then clear the error and seed again. The two interrupt-clear commands behave differently. A plain interrupt clear does nothing while an error is recorded. An error clear wipes the error and the completion flags together.

Top module: `rng_ctrl`

## Requirements
- R1: After reset, the control register (offset 0x08) reads 0x60, which means both interrupts are masked. The status register (0x0C) and the error register (0x10) read 0, and `irq` is low.
- R2: The command register (0x04) always reads 0. Its bits act as one-cycle triggers: bit 0 starts a self-test, bit 1 starts a seeding run, bit 4 clears the interrupt and bit 5 clears the error.
- R3: A seeding run ends SEED_CYCLES cycles after the command and sets status bit 5. When FAIL_FIRST_SEED is 1, the first run after reset fails. It sets error register bit 3 and status bit 16, and the FIFO stays empty.
- R4: A seeding run that ends without error fills the FIFO to DEPTH words. The fill level is reported in status bits 12:8.
- R5: A self-test ends TEST_CYCLES cycles after the command and sets status bit 4 without recording an error.
- R6: `irq` is high while a completion flag is set and control bit 5 is 0, or while an error is recorded and control bit 6 is 0. With both control bits set, `irq` stays low.
- R7: The interrupt-clear command clears both completion flags, and so drops the completion interrupt, only when the error register is 0. While an error is recorded, it changes nothing.
- R8: The error-clear command clears the error register, status bit 16 and both completion flags.
- R9: Reads of the FIFO register (0x14) return xorshift32 words in order. The generator applies x^=x<<13, x^=x>>17, x^=x<<5, and the first word after each successful seeding run is SEED_INIT. Each read of a full FIFO lowers the level to DEPTH-1 for one cycle, and the block then refills one word per cycle.
- R10: A read of an empty FIFO returns 0 and the level stays 0.
- R11: A start command is ignored while an operation is running. Reads of an unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read; a FIFO read pops at the clock edge |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the same cycle as busRdEn, 0 otherwise |
| irq | output | 1 | Interrupt, level sensitive |

## Verification
The assertions assume a single access per cycle: `busWrEn` and `busRdEn` are never high together. They also assume no clear command arrives in the same cycle that an operation finishes, so the clear properties are qualified on the block being idle. The bench drives one access per task, each one cycle long at the falling clock edge. It issues clear commands only after polling the status register for the completion flag, so every clear lands while the block is idle.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;
  localparam int WORD_W = 32;

  localparam int OFS_CMD    = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_STATUS = 'h0C;
  localparam int OFS_ERR    = 'h10;
  localparam int OFS_FIFO   = 'h14;

  localparam int CMD_TEST   = 0;
  localparam int CMD_SEED   = 1;
  localparam int CMD_CLRINT = 4;
  localparam int CMD_CLRERR = 5;
  localparam int CTRL_MDONE = 5;
  localparam int CTRL_MERR  = 6;
  localparam int ST_TDONE   = 4;
  localparam int ST_SDONE   = 5;
  localparam int ST_LVL     = 8;
  localparam int ST_ERR     = 16;
  localparam int ERR_STAT   = 3;

  typedef struct packed {
    logic flush;
    logic loadSeed;
    logic pop;
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] xorshiftNext(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction
endpackage

// File: rtl/rng_ctrl_dp.sv
module rng_ctrl_dp
  import rng_ctrl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter logic [31:0] SEED_INIT = 32'h2545F491,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  output logic [LVL_W-1:0]  level,
  output logic [WORD_W-1:0] headWord
);
  logic [WORD_W-1:0] fifoMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [WORD_W-1:0] genState;
  logic              fillEn;
  logic              doPush, doPop;

  assign doPush   = fillEn && (level < LVL_W'(DEPTH));
  assign doPop    = stb.pop && (level != '0);
  assign headWord = fifoMem[rdPtr];

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[wrPtr] <= genState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      level    <= '0;
      fillEn   <= 1'b0;
      genState <= SEED_INIT;
    end else if (stb.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      fillEn <= 1'b0;
    end else begin
      if (stb.loadSeed) begin
        fillEn   <= 1'b1;
        genState <= SEED_INIT;
      end else if (doPush) begin
        genState <= xorshiftNext(genState);
      end
      if (doPush) wrPtr <= ptrInc(wrPtr);
      if (doPop)  rdPtr <= ptrInc(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rng_ctrl_ctl.sv
module rng_ctrl_ctl
  import rng_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int SEED_CYCLES     = 64,
  parameter int TEST_CYCLES     = 16,
  parameter bit FAIL_FIRST_SEED = 1'b1,
  parameter int LVL_W           = 5,
  localparam int MAX_CYC = (SEED_CYCLES > TEST_CYCLES) ? SEED_CYCLES : TEST_CYCLES,
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  input  logic [LVL_W-1:0]  level,
  input  logic [WORD_W-1:0] headWord,
  output dpStrobe_t         stb,
  output logic              irq,
  output logic              busy,
  output logic              errPresent,
  output logic              doneAny,
  output logic              maskDone,
  output logic              maskErr
);
  typedef enum logic [1:0] {OP_IDLE, OP_SEED, OP_TEST} op_e;

  op_e              opState;
  logic [CNT_W-1:0] cycCnt;
  logic             testDone, seedDone, statErr, failNext;
  logic             cmdWr, ctrlWr, startTest, startSeed, finish, clrInt, clrErr;

  assign cmdWr     = busWrEn && (busAddr == ADDR_W'(OFS_CMD));
  assign ctrlWr    = busWrEn && (busAddr == ADDR_W'(OFS_CTRL));
  assign busy      = (opState != OP_IDLE);
  assign startTest = cmdWr && !busy && busWrData[CMD_TEST];
  assign startSeed = cmdWr && !busy && busWrData[CMD_SEED] && !busWrData[CMD_TEST];
  assign finish    = busy && (cycCnt == '0);
  assign clrErr    = cmdWr && busWrData[CMD_CLRERR];
  assign clrInt    = cmdWr && busWrData[CMD_CLRINT] && !statErr;

  assign stb.flush    = startSeed;
  assign stb.loadSeed = finish && (opState == OP_SEED) && !failNext;
  assign stb.pop      = busRdEn && (busAddr == ADDR_W'(OFS_FIFO));

  assign doneAny    = testDone || seedDone;
  assign errPresent = statErr;
  assign irq        = (doneAny && !maskDone) || (statErr && !maskErr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opState  <= OP_IDLE;
      cycCnt   <= '0;
      testDone <= 1'b0;
      seedDone <= 1'b0;
      statErr  <= 1'b0;
      failNext <= FAIL_FIRST_SEED;
      maskDone <= 1'b1;
      maskErr  <= 1'b1;
    end else begin
      if (ctrlWr) begin
        maskDone <= busWrData[CTRL_MDONE];
        maskErr  <= busWrData[CTRL_MERR];
      end
      if (clrErr) begin
        statErr  <= 1'b0;
        testDone <= 1'b0;
        seedDone <= 1'b0;
      end else if (clrInt) begin
        testDone <= 1'b0;
        seedDone <= 1'b0;
      end
      if (startTest) begin
        opState  <= OP_TEST;
        cycCnt   <= CNT_W'(TEST_CYCLES - 1);
        testDone <= 1'b0;
      end else if (startSeed) begin
        opState  <= OP_SEED;
        cycCnt   <= CNT_W'(SEED_CYCLES - 1);
        seedDone <= 1'b0;
      end else if (finish) begin
        opState <= OP_IDLE;
        if (opState == OP_TEST) begin
          testDone <= 1'b1;
        end else begin
          seedDone <= 1'b1;
          if (failNext) begin
            statErr  <= 1'b1;
            failNext <= 1'b0;
          end
        end
      end else if (busy) begin
        cycCnt <= cycCnt - 1'b1;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        ADDR_W'(OFS_CTRL): begin
          busRdData[CTRL_MDONE] = maskDone;
          busRdData[CTRL_MERR]  = maskErr;
        end
        ADDR_W'(OFS_STATUS): begin
          busRdData[ST_TDONE]         = testDone;
          busRdData[ST_SDONE]         = seedDone;
          busRdData[ST_LVL +: LVL_W]  = level;
          busRdData[ST_ERR]           = statErr;
        end
        ADDR_W'(OFS_ERR):  busRdData[ERR_STAT] = statErr;
        ADDR_W'(OFS_FIFO): busRdData = (level != '0) ? headWord : '0;
        default:           busRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int DEPTH           = 16,
  parameter int SEED_CYCLES     = 64,
  parameter int TEST_CYCLES     = 16,
  parameter bit FAIL_FIRST_SEED = 1'b1,
  parameter logic [31:0] SEED_INIT = 32'h2545F491,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              irq
);
  dpStrobe_t        stb;
  logic [LVL_W-1:0] level;
  logic [31:0]      headWord;
  logic             busy, errPresent, doneAny, maskDone, maskErr;

  rng_ctrl_ctl #(
    .ADDR_W(ADDR_W), .SEED_CYCLES(SEED_CYCLES), .TEST_CYCLES(TEST_CYCLES),
    .FAIL_FIRST_SEED(FAIL_FIRST_SEED), .LVL_W(LVL_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .level(level), .headWord(headWord), .stb(stb), .irq(irq), .busy(busy),
    .errPresent(errPresent), .doneAny(doneAny), .maskDone(maskDone), .maskErr(maskErr)
  );

  rng_ctrl_dp #(.DEPTH(DEPTH), .SEED_INIT(SEED_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .level(level), .headWord(headWord)
  );
endmodule

// File: rtl/rng_ctrl_chk.sv
module rng_ctrl_chk
  import rng_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              irq,
  input logic [LVL_W-1:0]  level,
  input logic              busy,
  input logic              errPresent,
  input logic              doneAny,
  input logic              maskDone,
  input logic              maskErr
);
  logic cmdWrite, fifoRead;
  assign cmdWrite = busWrEn && (busAddr == ADDR_W'(OFS_CMD));
  assign fifoRead = busRdEn && (busAddr == ADDR_W'(OFS_FIFO));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  assert_cmd_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(OFS_CMD)) |-> busRdData == '0);

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (maskDone && maskErr) |-> !irq);

  assert_clrint_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busWrData[CMD_CLRINT] && !busWrData[CMD_CLRERR] && errPresent && !busy)
      |=> (errPresent && $stable(irq)));

  assert_clrerr_wipes_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && busWrData[CMD_CLRERR] && !busy) |=> (!errPresent && !doneAny));

  assert_pop_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRead && level == LVL_W'(DEPTH)) |=> level == LVL_W'(DEPTH - 1));

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fifoRead && level == '0) |-> busRdData == '0);
endmodule

bind rng_ctrl rng_ctrl_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/rng_ctrl_tb.sv
module rng_ctrl_tb;
  localparam int SEED_CYC = 64;
  localparam int TEST_CYC = 16;
  localparam int DEPTH    = 16;
  localparam logic [31:0] SEED0 = 32'h2545F491;
  localparam logic [7:0] A_CMD = 8'h04, A_CTRL = 8'h08, A_STAT = 8'h0C,
                         A_ERR = 8'h10, A_FIFO = 8'h14;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] expGen;

  always #5 clk = ~clk;

  rng_ctrl #(.DEPTH(DEPTH), .SEED_CYCLES(SEED_CYC), .TEST_CYCLES(TEST_CYC),
             .FAIL_FIRST_SEED(1'b1), .SEED_INIT(SEED0)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .irq(irq));

  function automatic logic [31:0] modelNext(input logic [31:0] v);
    logic [31:0] r;
    r = v ^ (v << 13);
    r = r ^ (r >> 17);
    return r ^ (r << 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic waitStat(input int bitIdx, input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(A_STAT, s);
      if (s[bitIdx]) return;
    end
    chk("poll status bit", 32'd0, 32'd1);
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h60);
    rd(A_STAT, v); chk("R1 status", v, 32'h0);
    rd(A_ERR, v);  chk("R1 error", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic tEmptyAndCmd();
    logic [31:0] v;
    rd(A_FIFO, v); chk("R10 empty data", v, 32'h0);
    rd(A_STAT, v); chk("R10 level zero", {27'd0, v[12:8]}, 32'd0);
    wr(A_CTRL, 32'h0);
    rd(A_CMD, v);  chk("R2 cmd reads zero", v, 32'h0);
    rd(8'h3C, v);  chk("R11 unmapped read", v, 32'h0);
  endtask

  task automatic tFailedSeed();
    logic [31:0] v;
    wr(A_CMD, 32'h2);
    repeat (SEED_CYC / 2) @(negedge clk);
    rd(A_STAT, v); chk("R3 not done early", {31'd0, v[5]}, 32'd0);
    waitStat(5, SEED_CYC);
    rd(A_ERR, v);  chk("R3 stat error bit3", v, 32'h8);
    rd(A_STAT, v); chk("R3 status err+done", v, 32'h0001_0020);
    chk("R6 irq on error", {31'd0, irq}, 32'd1);
    wr(A_CMD, 32'h10);
    rd(A_ERR, v);  chk("R7 clear-int blocked, error kept", v, 32'h8);
    rd(A_STAT, v); chk("R7 clear-int blocked, done kept", {31'd0, v[5]}, 32'd1);
    chk("R7 irq kept", {31'd0, irq}, 32'd1);
    wr(A_CMD, 32'h20);
    rd(A_ERR, v);  chk("R8 error cleared", v, 32'h0);
    rd(A_STAT, v); chk("R8 status cleared", v, 32'h0);
    chk("R8 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic tGoodSeed();
    logic [31:0] v;
    wr(A_CMD, 32'h2);
    waitStat(5, SEED_CYC + 8);
    rd(A_ERR, v); chk("R4 no error", v, 32'h0);
    chk("R6 irq on done", {31'd0, irq}, 32'd1);
    wr(A_CMD, 32'h10);
    chk("R7 clear-int drops irq", {31'd0, irq}, 32'd0);
    rd(A_STAT, v); chk("R7 done cleared", {26'd0, v[5:0]}, 32'd0);
    repeat (DEPTH + 4) @(negedge clk);
    rd(A_STAT, v); chk("R4 full level", {27'd0, v[12:8]}, DEPTH);
  endtask

  task automatic tPop();
    logic [31:0] v;
    expGen = SEED0;
    rd(A_FIFO, v); chk("R9 word 0", v, expGen);
    expGen = modelNext(expGen);
    rd(A_STAT, v); chk("R9 level drop", {27'd0, v[12:8]}, DEPTH - 1);
    rd(A_STAT, v); chk("R9 level refill", {27'd0, v[12:8]}, DEPTH);
    for (int i = 1; i < 24; i++) begin
      rd(A_FIFO, v); chk("R9 word order", v, expGen);
      expGen = modelNext(expGen);
    end
  endtask

  task automatic tSelfTest();
    logic [31:0] v;
    wr(A_CTRL, 32'h20);
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);  // seed start while busy: ignored
    waitStat(4, TEST_CYC + 8);
    rd(A_STAT, v);
    chk("R5 self-test done", {31'd0, v[4]}, 32'd1);
    chk("R11 seed ignored while busy", {31'd0, v[5]}, 32'd0);
    chk("R11 fifo not flushed", {27'd0, v[12:8]}, DEPTH);
    rd(A_ERR, v);  chk("R5 no error", v, 32'h0);
    chk("R6 done masked", {31'd0, irq}, 32'd0);
    wr(A_CTRL, 32'h0);
    chk("R6 done unmasked", {31'd0, irq}, 32'd1);
    wr(A_CMD, 32'h10);
    chk("R7 clear after self-test", {31'd0, irq}, 32'd0);
    rd(A_FIFO, v); chk("R9 sequence continues", v, expGen);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEmptyAndCmd();
    tFailedSeed();
    tGoodSeed();
    tPop();
    tSelfTest();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule